// File: doc/BRIEF.md
# Interrupt Pin Request and EOI Delivery Engine

This block sits between a bank of interrupt input pins and the message path that carries interrupts to processors. It keeps a request bit, a remote in-service flag and a routing entry for each pin. From these it decides when an interrupt has to be delivered, and it raises one delivery request at a time that names the pin. A pin can be edge-triggered or level-triggered, and it can be masked. Level-triggered pins wait for an end-of-interrupt (EOI) before they can fire again. When an EOI is broadcast with a matching vector and the pin's request is still asserted, the pin is re-delivered at once.

Software or a neighbouring block rewrites routing entries through a one-cycle write port. The delivery side uses a valid/accept handshake. A pin that keeps asserting after every EOI is throttled. After `STORM_LIMIT` back-to-back EOI re-deliveries, the next one is deferred by `DEFER_CYCLES` clocks. When the deferral expires, every level pin that is eligible is served, lowest pin first.

Top module: `irq_dlv_engine`

## Requirements
- R1: A low pin clears its request bit and cancels any delivery still waiting for that pin. A pin that goes high and then low again while the output is busy is never delivered.
- R2: An edge pin (entry trigger bit 0) is delivered once when its request bit goes from 0 to 1. Holding the pin high produces no further delivery.
- R3: A level pin (entry trigger bit 1) is not delivered while its remote flag is set. A new assertion in that state is dropped.
- R4: A masked pin is never delivered, but its request bit is kept. Unmasking a level pin whose request is still set therefore delivers it.
- R5: `dlv_valid` and `dlv_pin` hold steady until `dlv_ack`. Accepting a level pin sets that pin's remote flag.
- R6: A level-type EOI (`eoi_level`=1) clears the remote flag of every level entry with a matching vector. Each such entry that is unmasked and still has its request set is re-delivered, with the request appearing on the second clock edge after the EOI. An EOI with `eoi_level`=0 or with a non-matching vector has no effect.
- R7: While `directed_eoi` is 1, broadcast EOIs neither clear remote flags nor cause re-delivery.
- R8: Each pin counts successive EOI re-deliveries. The re-delivery that would bring the count to `STORM_LIMIT` is deferred by `DEFER_CYCLES` clocks, and the count restarts from zero. A matching EOI that causes no re-delivery, because the pin is masked or its request is clear, also zeroes the count.
- R9: A routing-entry write clears that pin's remote flag. If the new entry is level-triggered and unmasked and the request bit is set, the pin is delivered.
- R10: When a deferral expires, every level pin with its request set, its remote flag clear and its entry unmasked is queued for delivery.
- R11: Pending deliveries are issued lowest pin index first.
- R12: After reset every entry is masked, no delivery is requested, and pins raised before any entry write are not delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_level | input | NPINS | Current level of each interrupt pin |
| cfg_we | input | 1 | Routing entry write strobe |
| cfg_pin | input | PIN_W | Pin whose entry is written |
| cfg_vector | input | VEC_W | New vector |
| cfg_trig | input | 1 | New trigger mode: 0 edge, 1 level |
| cfg_mask | input | 1 | New mask bit: 1 masked |
| eoi_valid | input | 1 | EOI broadcast strobe |
| eoi_vector | input | VEC_W | Vector carried by the EOI |
| eoi_level | input | 1 | 1 when the EOI is of level type |
| directed_eoi | input | 1 | Global directed-EOI enable |
| dlv_valid | output | 1 | Delivery request outstanding |
| dlv_pin | output | PIN_W | Pin index of the outstanding request |
| dlv_ack | input | 1 | Delivery accepted |

## Verification
The assertions assume that `dlv_ack` is only raised while `dlv_valid` is high, and that `cfg_pin` always names an existing pin. They also assume that the EOI handshake never targets an entry in the same cycle as that entry's acceptance. The stimulus meets these assumptions because `dlv_ack` is a one-cycle pulse driven only after a request has been observed, and every entry write and EOI is issued while the output is idle or in a cycle apart from the acceptance. Random pin sets are raised only while every pin is configured as edge-triggered with a unique vector, so the expected order comes from the lowest-index rule alone.

// File: rtl/irq_eng_pkg.sv
package irq_eng_pkg;

   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_e;

endpackage

// File: rtl/irq_pin_slice.sv
module irq_pin_slice #(
   parameter int VEC_W       = 8,
   parameter int STORM_LIMIT = 10000,
   localparam int CNT_W      = $clog2(STORM_LIMIT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_in,
   input  logic             cfg_wr,
   input  logic [VEC_W-1:0] cfg_vector,
   input  logic             cfg_level,
   input  logic             cfg_mask,
   input  logic             eoi_valid,
   input  logic [VEC_W-1:0] eoi_vector,
   input  logic             eoi_level,
   input  logic             directed_eoi,
   input  logic             defer_fire,
   input  logic             grant_ack,
   output logic             pend,
   output logic             defer_req
);

   logic             irr_q, remote_q, pend_q, mask_q, level_q;
   logic [VEC_W-1:0] vec_q;
   logic [CNT_W-1:0] storm_q;

   logic             eoi_hit, eligible, storm_top, redo_now, rise, mask_eff, rem_blk, set_src;
   logic             pend_d, remote_d;
   logic [CNT_W-1:0] storm_d;

   always_comb begin
      eoi_hit   = eoi_valid & eoi_level & ~directed_eoi & level_q & (eoi_vector == vec_q);
      eligible  = ~mask_q & irr_q;
      storm_top = (storm_q == CNT_W'(STORM_LIMIT - 1));
      redo_now  = eoi_hit & eligible & ~storm_top;
      defer_req = eoi_hit & eligible & storm_top;
      rise      = pin_in & ~irr_q;
      mask_eff  = cfg_wr ? cfg_mask : mask_q;
      rem_blk   = remote_q | (grant_ack & level_q);
      set_src   = (rise & (~level_q | ~rem_blk))
                | redo_now
                | (cfg_wr & cfg_level & irr_q)
                | (defer_fire & level_q & irr_q & ~rem_blk);

      pend_d = pend_q;
      if (grant_ack)          pend_d = 1'b0;
      if (set_src)            pend_d = 1'b1;
      if (mask_eff || !pin_in) pend_d = 1'b0;

      remote_d = remote_q;
      if (grant_ack && level_q) remote_d = 1'b1;
      if (cfg_wr || eoi_hit)    remote_d = 1'b0;

      storm_d = storm_q;
      if (eoi_hit) storm_d = (eligible && !storm_top) ? storm_q + 1'b1 : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr_q    <= 1'b0;
         remote_q <= 1'b0;
         pend_q   <= 1'b0;
         mask_q   <= 1'b1;
         level_q  <= 1'b0;
         vec_q    <= '0;
         storm_q  <= '0;
      end else begin
         irr_q    <= pin_in;
         remote_q <= remote_d;
         pend_q   <= pend_d;
         storm_q  <= storm_d;
         if (cfg_wr) begin
            mask_q  <= cfg_mask;
            level_q <= cfg_level;
            vec_q   <= cfg_vector;
         end
      end
   end

   assign pend = pend_q;

   assert_low_cancel_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_in |=> !pend_q);
   assert_level_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && level_q) |-> !remote_q);
   assert_masked_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> !mask_q);
   assert_ack_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_ack && level_q && !cfg_wr && !eoi_hit) |=> remote_q);
   assert_storm_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      storm_q <= CNT_W'(STORM_LIMIT - 1));

endmodule

// File: rtl/irq_low_pick.sv
module irq_low_pick #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/irq_defer_timer.sv
module irq_defer_timer #(
   parameter int DELAY = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic fire
);

   generate
      if (DELAY <= 1) begin : g_pulse
         logic fire_q;
         always_ff @(posedge clk) begin
            if (!rst_n) fire_q <= 1'b0;
            else        fire_q <= start;
         end
         assign fire = fire_q;
      end else begin : g_count
         localparam int CW = $clog2(DELAY + 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (start && (cnt_q <= CW'(1)))
               cnt_q <= CW'(DELAY);
            else if (cnt_q != '0)
               cnt_q <= cnt_q - 1'b1;
         end
         assign fire = (cnt_q == CW'(1));

         assert_defer_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q > CW'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1));
      end
   endgenerate

endmodule

// File: rtl/irq_dlv_engine.sv
module irq_dlv_engine
   import irq_eng_pkg::*;
#(
   parameter int NPINS        = 8,
   parameter int VEC_W        = 8,
   parameter int STORM_LIMIT  = 10000,
   parameter int DEFER_CYCLES = 256,
   localparam int PIN_W       = (NPINS > 1) ? $clog2(NPINS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_level,
   input  logic             cfg_we,
   input  logic [PIN_W-1:0] cfg_pin,
   input  logic [VEC_W-1:0] cfg_vector,
   input  logic             cfg_trig,
   input  logic             cfg_mask,
   input  logic             eoi_valid,
   input  logic [VEC_W-1:0] eoi_vector,
   input  logic             eoi_level,
   input  logic             directed_eoi,
   output logic             dlv_valid,
   output logic [PIN_W-1:0] dlv_pin,
   input  logic             dlv_ack
);

   if (NPINS < 2)        $error("NPINS must be at least 2");
   if (VEC_W < 1)        $error("VEC_W must be at least 1");
   if (STORM_LIMIT < 2)  $error("STORM_LIMIT must be at least 2");
   if (DEFER_CYCLES < 1) $error("DEFER_CYCLES must be at least 1");

   logic [NPINS-1:0] pend_vec, defer_vec;
   logic             defer_fire, pick_any;
   logic [PIN_W-1:0] pick_idx;
   logic             dlv_valid_q;
   logic [PIN_W-1:0] dlv_pin_q;
   logic             cfg_is_level;

   assign cfg_is_level = (cfg_trig == TRIG_LEVEL);

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      irq_pin_slice #(
         .VEC_W      (VEC_W),
         .STORM_LIMIT(STORM_LIMIT)
      ) u_slice (
         .clk         (clk),
         .rst_n       (rst_n),
         .pin_in      (pin_level[i]),
         .cfg_wr      (cfg_we && (cfg_pin == PIN_W'(i))),
         .cfg_vector  (cfg_vector),
         .cfg_level   (cfg_is_level),
         .cfg_mask    (cfg_mask),
         .eoi_valid   (eoi_valid),
         .eoi_vector  (eoi_vector),
         .eoi_level   (eoi_level),
         .directed_eoi(directed_eoi),
         .defer_fire  (defer_fire),
         .grant_ack   (dlv_valid_q && dlv_ack && (dlv_pin_q == PIN_W'(i))),
         .pend        (pend_vec[i]),
         .defer_req   (defer_vec[i])
      );
   end

   irq_low_pick #(.N(NPINS), .IDX_W(PIN_W)) u_pick (
      .req(pend_vec),
      .any(pick_any),
      .idx(pick_idx)
   );

   irq_defer_timer #(.DELAY(DEFER_CYCLES)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .start(|defer_vec),
      .fire (defer_fire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dlv_valid_q <= 1'b0;
         dlv_pin_q   <= '0;
      end else if (dlv_valid_q) begin
         if (dlv_ack) dlv_valid_q <= 1'b0;
      end else if (pick_any) begin
         dlv_valid_q <= 1'b1;
         dlv_pin_q   <= pick_idx;
      end
   end

   assign dlv_valid = dlv_valid_q;
   assign dlv_pin   = dlv_pin_q;

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv_valid && !dlv_ack) |=> (dlv_valid && $stable(dlv_pin)));
   assert_ack_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv_valid && dlv_ack) |=> !dlv_valid);

endmodule

// File: tb/sim_irq_dlv_engine.sv
module sim_irq_dlv_engine;

   localparam int NP = 8;
   localparam int VW = 8;
   localparam int SL = 12;
   localparam int DC = 30;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pin_level = '0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_pin = '0;
   logic [VW-1:0] cfg_vector = '0;
   logic          cfg_trig = 1'b0;
   logic          cfg_mask = 1'b1;
   logic          eoi_valid = 1'b0;
   logic [VW-1:0] eoi_vector = '0;
   logic          eoi_level = 1'b0;
   logic          directed_eoi = 1'b0;
   logic          dlv_valid;
   logic [2:0]    dlv_pin;
   logic          dlv_ack = 1'b0;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   irq_dlv_engine #(.NPINS(NP), .VEC_W(VW), .STORM_LIMIT(SL), .DEFER_CYCLES(DC)) u0 (
      .clk(clk), .rst_n(rst_n), .pin_level(pin_level),
      .cfg_we(cfg_we), .cfg_pin(cfg_pin), .cfg_vector(cfg_vector),
      .cfg_trig(cfg_trig), .cfg_mask(cfg_mask),
      .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_level(eoi_level),
      .directed_eoi(directed_eoi),
      .dlv_valid(dlv_valid), .dlv_pin(dlv_pin), .dlv_ack(dlv_ack)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic nx();
      @(negedge clk);
   endtask

   task automatic cfg(input int p, input int v, input bit lvl, input bit m);
      cfg_we = 1'b1; cfg_pin = 3'(p); cfg_vector = VW'(v); cfg_trig = lvl; cfg_mask = m;
      nx();
      cfg_we = 1'b0;
   endtask

   task automatic eoi(input int v, input bit lvl);
      eoi_valid = 1'b1; eoi_vector = VW'(v); eoi_level = lvl;
      nx();
      eoi_valid = 1'b0;
   endtask

   task automatic ack();
      dlv_ack = 1'b1;
      nx();
      dlv_ack = 1'b0;
   endtask

   task automatic expect_dlv(input int p, input string tag);
      chk(dlv_valid === 1'b1, tag, int'(dlv_valid), 1);
      chk(int'(dlv_pin) == p, tag, int'(dlv_pin), p);
      ack();
   endtask

   task automatic expect_idle(input int n, input string tag);
      for (int k = 0; k < n; k++) begin
         nx();
         chk(dlv_valid === 1'b0, tag, int'(dlv_valid), 0);
      end
   endtask

   function automatic int lowest(input logic [NP-1:0] m);
      for (int i = 0; i < NP; i++) if (m[i]) return i;
      return -1;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL R12 watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) nx();
      rst_n = 1'b1;
      nx();
      // R12: reset state, pins before configuration
      chk(dlv_valid === 1'b0, "R12 reset valid", int'(dlv_valid), 0);
      pin_level[0] = 1'b1;
      expect_idle(4, "R12 masked after reset");
      pin_level[0] = 1'b0;
      nx();

      // R2: edge delivery once per rising request
      cfg(2, 8'h22, 1'b0, 1'b0);
      cfg(3, 8'h33, 1'b0, 1'b0);
      pin_level[2] = 1'b1; nx(); nx();
      expect_dlv(2, "R2 edge first");
      expect_idle(5, "R2 held high");
      pin_level[2] = 1'b0; nx(); nx();
      pin_level[2] = 1'b1; nx(); nx();
      // R5: hold while not accepted; R1: short pulse on pin 3 cancelled
      chk(dlv_valid === 1'b1 && dlv_pin == 3'd2, "R5 busy pin2", int'(dlv_pin), 2);
      pin_level[3] = 1'b1; nx(); nx();
      pin_level[3] = 1'b0; nx(); nx();
      chk(dlv_valid === 1'b1 && dlv_pin == 3'd2, "R5 hold stable", int'(dlv_pin), 2);
      ack();
      expect_idle(4, "R1 cancelled pulse");
      pin_level[2] = 1'b0; nx();

      // R3/R5/R6/R7: level pin handling
      cfg(4, 8'h44, 1'b1, 1'b0);
      pin_level[4] = 1'b1; nx(); nx();
      expect_dlv(4, "R5 level first");
      pin_level[4] = 1'b0; nx(); nx();
      pin_level[4] = 1'b1; nx();
      expect_idle(4, "R3 remote blocks");
      eoi(8'h45, 1'b1);
      expect_idle(3, "R6 vector mismatch");
      eoi(8'h44, 1'b0);
      expect_idle(3, "R6 edge eoi ignored");
      directed_eoi = 1'b1;
      eoi(8'h44, 1'b1);
      expect_idle(3, "R7 directed eoi");
      directed_eoi = 1'b0;
      eoi(8'h44, 1'b1); nx();
      expect_dlv(4, "R6 eoi redelivery");

      // R4/R9: mask keeps request, unmask delivers
      cfg(4, 8'h44, 1'b1, 1'b1);
      expect_idle(4, "R4 masked no delivery");
      cfg(4, 8'h44, 1'b1, 1'b0); nx();
      expect_dlv(4, "R9 unmask delivers kept request");
      pin_level[4] = 1'b0;
      cfg(4, 8'h44, 1'b1, 1'b1);
      nx();

      // R8/R10: storm throttling on pins 1 and 6 sharing a vector
      cfg(1, 8'h11, 1'b1, 1'b0);
      cfg(6, 8'h11, 1'b1, 1'b0);
      pin_level[1] = 1'b1; pin_level[6] = 1'b1; nx(); nx();
      expect_dlv(1, "R11 storm setup pin1");
      nx();
      expect_dlv(6, "R11 storm setup pin6");
      for (int k = 1; k <= SL; k++) begin
         eoi(8'h11, 1'b1);
         if (k < SL) begin
            nx();
            expect_dlv(1, "R8 immediate pin1");
            nx();
            expect_dlv(6, "R8 immediate pin6");
         end else begin
            expect_idle(DC, "R8 deferred window");
            nx();
            expect_dlv(1, "R10 deferred serve pin1");
            nx();
            expect_dlv(6, "R10 deferred serve pin6");
         end
      end
      for (int k = 0; k < 4; k++) begin
         eoi(8'h11, 1'b1); nx();
         expect_dlv(1, "R8 count restarted pin1");
         nx();
         expect_dlv(6, "R8 count restarted pin6");
      end
      pin_level[1] = 1'b0; pin_level[6] = 1'b0; nx();
      eoi(8'h11, 1'b1);
      expect_idle(3, "R8 no redelivery when low");
      pin_level[1] = 1'b1; pin_level[6] = 1'b1; nx(); nx();
      expect_dlv(1, "R8 rearm pin1");
      nx();
      expect_dlv(6, "R8 rearm pin6");
      for (int k = 1; k < SL; k++) begin
         eoi(8'h11, 1'b1); nx();
         expect_dlv(1, "R8 count zeroed by idle eoi pin1");
         nx();
         expect_dlv(6, "R8 count zeroed by idle eoi pin6");
      end
      pin_level = '0;
      nx();

      // R11: random pin sets on edge entries, lowest first
      for (int i = 0; i < NP; i++) cfg(i, 8'h80 + i, 1'b0, 1'b0);
      for (int t = 0; t < 20; t++) begin
         logic [NP-1:0] m;
         m = NP'($urandom);
         if (m == '0) m = NP'(1);
         pin_level = m; nx(); nx();
         while (m != '0) begin
            expect_dlv(lowest(m), "R11 lowest first");
            m[lowest(m)] = 1'b0;
            nx();
         end
         expect_idle(2, "R2 no extra delivery");
         pin_level = '0;
         nx();
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule